// File: doc/BRIEF.md
# Multi-Core Clock Divider Bank

This block takes one parent clock and produces a divided-rate clock enable for each of up to four cores. Each core runs at the parent rate divided by 1, 2 or 3. Software programs the ratios through a small register port. It writes a wanted ratio for every core into one shared staging register. It then commits a chosen subset of cores in one step: it writes the control register with a reload-mask bit for each core it wants to update, together with a global trigger bit.

A committed ratio does not replace the running ratio at once. Each core finishes the output period it is in, and then starts its first period at the new ratio. No shortened or merged pulse reaches that core's enable output. Cores that were left out of the mask keep the ratio they already run, even if their staged field has changed. Once the switch is done, software may clear the mask and trigger bits. Clearing them does not undo any committed ratio.

Register access uses a request channel (valid/ready) and a read-response channel (valid/ready). A request transfers on a clock edge where `req_valid` and `req_ready` are both high. Only reads produce a response. While a response is held because `rsp_ready` is low, `req_ready` stays low, and `rsp_valid` and `rsp_rdata` stay unchanged.

Top module: `cdb_top`

## Requirements
- R1: After reset the control register reads 0x00000000, the staging register reads 0x01010101, and every `core_en` bit is high on every cycle.
- R2: A read accepted on an edge gives `rsp_valid` high after that edge. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds its value.
- R3: The control register is at byte address 0x0 and the staging register is at 0xC. Core c's staged field is bits [8c+5:8c] of the staging register, and bits 6 and 7 of each byte read 0. A write to any other address has no effect, and a read of any other address returns 0.
- R4: In the control register, bit 20+c is core c's reload mask and bit 24 is the trigger. All other control bits read 0.
- R5: Writing the staging register does not change any core's output rate until a trigger commits it.
- R6: A control write that takes bit 24 from 0 to 1 commits the staged field of every core whose mask bit is 1 in that same write. Cores whose mask bit is 0 keep their ratio. A control write that finds bit 24 already at 1 commits nothing.
- R7: A staged field of 0 commits as ratio 1. A staged field above 3 commits as ratio 3.
- R8: With active ratio D, `core_en` of that core is high on one cycle out of every D.
- R9: A new ratio takes effect only at the end of the current period. The first pulse under the new ratio comes exactly one old period after the last pulse under the old ratio.
- R10: Clearing the mask bits and the trigger bit leaves every committed ratio in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Read data |
| core_en | output | N_CORES | Divided-rate enable, one bit per core |

## Verification
A read's data is due in the cycle after the edge that accepts it. The scoreboard queues the expected word when the request is accepted, and compares it when a response handshake is seen, half a cycle before that handshake's edge. A trigger write sets a pending commit on its accept edge. The new ratio then appears on `core_en` at the end of that core's running period, so the rate checks first wait several periods before they measure gaps between pulses. The boundary check is different: it issues the trigger at the negative edge just after a pulse, and it counts the negative edges up to the next pulse, which must equal the old ratio.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int FIELD_W = 6;
  localparam int LANE_W  = 8;
  localparam int RATIO_W = 2;
  localparam int MASK_LSB = 20;
  localparam int TRIG_BIT = 24;

  function automatic logic [RATIO_W-1:0] ratio_clamp(input logic [FIELD_W-1:0] f);
    if (f == '0)
      return RATIO_W'(1);
    else if (f > FIELD_W'(3))
      return RATIO_W'(3);
    else
      return f[RATIO_W-1:0];
  endfunction
endpackage

// File: rtl/cdb_regs.sv
module cdb_regs
  import cdb_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
  parameter logic [ADDR_W-1:0] VAL_OFS  = 'hC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [N_CORES*FIELD_W-1:0] staged_flat,
  output logic                       load_pulse,
  output logic [N_CORES-1:0]         load_mask
);
  logic [FIELD_W-1:0] staged_q [N_CORES];
  logic [N_CORES-1:0] mask_q;
  logic               trig_q;
  logic               accept, wr_ctrl, wr_val;
  logic [DATA_W-1:0]  rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_ctrl   = accept && req_write && (req_addr == CTRL_OFS);
  assign wr_val    = accept && req_write && (req_addr == VAL_OFS);

  assign load_pulse = wr_ctrl && req_wdata[TRIG_BIT] && !trig_q;
  assign load_mask  = req_wdata[MASK_LSB +: N_CORES];

  always_comb begin
    rd_mux = '0;
    if (req_addr == CTRL_OFS) begin
      rd_mux[MASK_LSB +: N_CORES] = mask_q;
      rd_mux[TRIG_BIT]            = trig_q;
    end else if (req_addr == VAL_OFS) begin
      for (int c = 0; c < N_CORES; c++)
        rd_mux[c*LANE_W +: FIELD_W] = staged_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      trig_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      for (int c = 0; c < N_CORES; c++)
        staged_q[c] <= FIELD_W'(1);
    end else begin
      if (wr_ctrl) begin
        mask_q <= req_wdata[MASK_LSB +: N_CORES];
        trig_q <= req_wdata[TRIG_BIT];
      end
      if (wr_val) begin
        for (int c = 0; c < N_CORES; c++)
          staged_q[c] <= req_wdata[c*LANE_W +: FIELD_W];
      end
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_mux;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_flat
    assign staged_flat[c*FIELD_W +: FIELD_W] = staged_q[c];
  end

  // R2: a stalled response keeps its data
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R10: a control write with the trigger clear never commits
  a_r10_no_load_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && !req_wdata[TRIG_BIT]) |-> !load_pulse);
endmodule

// File: rtl/cdb_core_div.sv
module cdb_core_div
  import cdb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] staged_field,
  input  logic               load_req,
  output logic               core_en
);
  logic [RATIO_W-1:0] act_q, pend_val_q, cnt_q, req_ratio;
  logic               pend_q, at_wrap;

  assign req_ratio = ratio_clamp(staged_field);
  assign at_wrap   = (cnt_q == act_q - RATIO_W'(1));
  assign core_en   = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= RATIO_W'(1);
      pend_val_q <= RATIO_W'(1);
      cnt_q      <= '0;
      pend_q     <= 1'b0;
    end else if (at_wrap) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      if (load_req)
        act_q <= req_ratio;
      else if (pend_q)
        act_q <= pend_val_q;
    end else begin
      cnt_q <= cnt_q + RATIO_W'(1);
      if (load_req) begin
        pend_q     <= 1'b1;
        pend_val_q <= req_ratio;
      end
    end
  end

  // R7: active ratio is always legal
  a_r7_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
    act_q != '0);

  // R9: ratio changes only at a period boundary
  a_r9_switch_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(at_wrap));

  // R8: a pulse under ratio 2 or 3 is never followed by a pulse at once
  a_r8_no_short_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && act_q != RATIO_W'(1)) |=> !core_en);
endmodule

// File: rtl/cdb_top.sv
module cdb_top
  import cdb_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_rdata,
  output logic [N_CORES-1:0] core_en
);
  localparam int DATA_W = 32;

  logic [N_CORES*FIELD_W-1:0] staged_flat;
  logic                       load_pulse;
  logic [N_CORES-1:0]         load_mask;

  cdb_regs #(
    .N_CORES (N_CORES),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_rdata   (rsp_rdata),
    .staged_flat (staged_flat),
    .load_pulse  (load_pulse),
    .load_mask   (load_mask)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    cdb_core_div u_div (
      .clk          (clk),
      .rst_n        (rst_n),
      .staged_field (staged_flat[c*FIELD_W +: FIELD_W]),
      .load_req     (load_pulse && load_mask[c]),
      .core_en      (core_en[c])
    );
  end
endmodule

// File: tb/cdb_top_tb.sv
module cdb_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] core_en;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cdb_top #(.N_CORES(NC), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .core_en(core_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: pops the scoreboard on each response handshake
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected response", rsp_rdata, 32'hDEAD_BEEF);
        end else begin
          chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  // driver tasks, called at a negative edge
  task automatic bus_req(input logic wr, input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_req(1'b1, a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_req(1'b0, a, 32'h0);
  endtask

  task automatic gap_of(input int c, output int g);
    while (!core_en[c]) @(negedge clk);
    g = 0;
    do begin @(negedge clk); g++; end while (!core_en[c]);
  endtask

  task automatic chk_gap(input int c, input int exp, input string tag);
    int g;
    repeat (8) @(negedge clk);
    gap_of(c, g);
    chk(tag, 32'(g), 32'(exp));
    gap_of(c, g);
    chk(tag, 32'(g), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 core_en after reset", 32'(core_en), 32'hF);
    bus_read(8'h00, 32'h0000_0000, "R1 ctrl reset");
    bus_read(8'h0C, 32'h0101_0101, "R1 staging reset");

    // R3 lanes, upper field bits dropped
    bus_write(8'h0C, 32'hC740_C342);
    bus_read(8'h0C, 32'h0700_0302, "R3 staging lanes");
    // R5 staged values not yet active
    chk_gap(0, 1, "R5 core0 before trigger");
    chk_gap(1, 1, "R5 core1 before trigger");

    // R4 + R6: commit cores 0..2, junk bits dropped
    bus_write(8'h00, 32'h0170_00FF);
    bus_read(8'h00, 32'h0170_0000, "R4 ctrl readback");
    chk_gap(0, 2, "R8 core0 ratio 2");
    chk_gap(1, 3, "R8 core1 ratio 3");
    chk_gap(2, 1, "R7 core2 zero as 1");
    chk_gap(3, 1, "R6 core3 unmasked keeps 1");

    // R10 clear does not revert
    bus_write(8'h00, 32'h0000_0000);
    bus_read(8'h00, 32'h0000_0000, "R10 ctrl cleared");
    chk_gap(0, 2, "R10 core0 kept");
    chk_gap(1, 3, "R10 core1 kept");

    // R7 clamp above 3
    bus_write(8'h0C, 32'h3F00_0302);
    bus_write(8'h00, 32'h0180_0000);
    chk_gap(3, 3, "R7 core3 clamp to 3");

    // R6 no commit while trigger already set
    bus_write(8'h0C, 32'h3F00_0301);
    bus_write(8'h00, 32'h0110_0000);
    bus_read(8'h0C, 32'h3F00_0301, "R6 staging");
    chk_gap(0, 2, "R6 core0 no commit without rise");

    // R9 switch at boundary: core1 from 3 to 1
    bus_write(8'h00, 32'h0000_0000);
    bus_write(8'h0C, 32'h3F00_0101);
    repeat (3) @(negedge clk);
    while (!core_en[1]) @(negedge clk);
    bus_write(8'h00, 32'h0120_0000);
    g = 1;
    while (!core_en[1]) begin @(negedge clk); g++; end
    chk("R9 last old-period gap", 32'(g), 32'd3);
    @(negedge clk);
    chk("R9 first new-period pulse", 32'(core_en[1]), 32'd1);
    chk_gap(1, 1, "R9 core1 now ratio 1");

    // R3 unmapped address
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, 32'h0000_0000, "R3 unmapped read");
    bus_read(8'h0C, 32'h3F00_0101, "R3 unmapped write ignored");
    chk_gap(0, 2, "R3 core0 unchanged");

    // R2 back-pressure
    rsp_ready = 1'b0;
    bus_read(8'h0C, 32'h3F00_0101, "R2 held response");
    chk("R2 rsp_valid held", 32'(rsp_valid), 32'd1);
    chk("R2 req_ready low", 32'(req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R2 data stable", rsp_rdata, 32'h3F00_0101);
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 response drained", 32'(rsp_valid), 32'd0);
    chk("R2 scoreboard empty", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule